// File: doc/BRIEF.md
# Asynchronous DRAM Access Sequencer

This block is a synchronous controller for a 256K x 1 asynchronous DRAM whose cell address is time-multiplexed over one 9-bit address bus. A host hands it one request at a time: an 18-bit cell address, a write flag and one data bit. The controller produces registered row strobe, column strobe, write strobe, address bus and data-in signals. On every completed access it returns a one-cycle done pulse, and on reads it also returns the bit it sampled.

After reset the controller holds off for a parameterised power-up pause. It then issues a run of dummy row-strobe-only cycles to wake the array, and it repeats that run whenever the row strobe has been idle for longer than a retention window. Once a row is open it serves later requests to the same row by column strobes alone, which is page mode. The page closes on a row miss, on a refresh request, or before the row-strobe low-time budget would run out. A separate refresh scheduler asks for RAS-only cycles through a request/grant pair. All access delays are counted in clocks.

Top module: `dram_seq`

## Requirements
- R1: No row strobe falls earlier than P_PWRUP clocks after reset is released.
- R2: After the pause, WAKE_CNT row-strobe-only cycles (column strobe held high) are issued before `mem_ready` goes high. No column strobe falls while `mem_ready` is low.
- R3: The row part, host_addr[17:9], is on `dram_a` when the row strobe falls. The column part, host_addr[8:0], is on `dram_a` when the column strobe falls. `dram_a` never changes on the clock edge where either strobe falls.
- R4: Read data is sampled T_CAC clocks after the column strobe falls and is presented on `host_rdata` with a `host_done` pulse exactly one cycle wide. The two strobes are active low.
- R5: Writes are early writes. `dram_we_n` (low = write, high = read) is low at least one clock before the column strobe falls, stays stable while the column strobe is low, and `dram_d` carries the host bit.
- R6: A request to the row that is already open is served with a column strobe only, with no new row-strobe fall.
- R7: A request to a different row closes the open row (row strobe high, precharge) and opens the new row with a fresh row-strobe fall.
- R8: The row strobe never stays low for more than T_RAS_MAX clocks. A long same-row burst is split across several row openings.
- R9: `refr_req` is answered by a one-cycle `refr_gnt` and a RAS-only cycle with `refr_row` on the address bus and no column strobe. A pending refresh closes an open page first.
- R10: Between any two low periods the row strobe stays high for at least T_RP clocks.
- R11: If the row strobe has been high for IDLE_LIMIT clocks, `mem_ready` drops and WAKE_CNT dummy row cycles are issued again before the next access.
- R12: While reset is held, all three strobes are high, `host_done` is low and `mem_ready` is low.
- R13: The column strobe is low only while the row strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_valid | input | 1 | Host request present |
| host_addr | input | 18 | Cell address, row in the upper half |
| host_write | input | 1 | 1 = write, 0 = read |
| host_wdata | input | 1 | Bit to write |
| host_accept | output | 1 | One-cycle pulse: request taken |
| host_done | output | 1 | One-cycle pulse: access finished |
| host_rdata | output | 1 | Bit returned by the last read |
| refr_req | input | 1 | Refresh scheduler asks for a RAS-only cycle |
| refr_row | input | 9 | Row to refresh |
| refr_gnt | output | 1 | One-cycle pulse: refresh cycle started |
| mem_ready | output | 1 | Pause and wake-up complete |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write strobe, low = write |
| dram_a | output | 9 | Multiplexed address bus |
| dram_d | output | 1 | Data into the memory |
| dram_q | input | 1 | Data out of the memory |

## Verification
Several rules are checked by assertions on every cycle:
- the strobe ordering (column only inside row)
- address stability at each strobe fall
- the early fall and hold of the write strobe
- the row-low budget
- the precharge minimum
- the absence of any row strobe before the pause ends
- the one-cycle width of the done and grant pulses

Other behaviour can only be shown by the bench's scenarios, which use a behavioural memory model:
- that data really round-trips through the row/column split
- that page hits avoid a row strobe while misses and refreshes force one
- that the read sample lands T_CAC clocks after the column strobe
- that an idle gap triggers a fresh wake-up run

// File: rtl/dseq_pkg.sv
package dseq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,   // row strobe high, precharge met
    ST_AROW,   // row address on bus, strobe falls next edge
    ST_RCD,    // row open, column set up, waiting to strobe
    ST_CAS,    // column strobe low, waiting to sample
    ST_PAGE,   // row open, column strobe high, deciding
    ST_CPW,    // page column set up, strobe falls next edge
    ST_RONLY,  // row-only cycle (refresh or wake dummy)
    ST_PRE     // row strobe high, counting precharge
  } dseq_state_e;

  typedef enum logic [1:0] {
    OP_HOST,
    OP_REFRESH,
    OP_WAKE
  } dseq_op_e;

endpackage

// File: rtl/dseq_wake.sv
module dseq_wake #(
  parameter int P_PWRUP    = 40000,
  parameter int WAKE_CNT   = 8,
  parameter int IDLE_LIMIT = 800000
) (
  input  logic clk,
  input  logic rst,
  input  logic ras_n,
  output logic pwr_done,
  output logic wake_pend
);

  localparam int PW_W = $clog2(P_PWRUP + 1);
  localparam int ID_W = $clog2(IDLE_LIMIT + 1);
  localparam int WK_W = $clog2(WAKE_CNT + 1);

  logic [PW_W-1:0] pwr_cnt;
  logic [ID_W-1:0] idle_cnt;
  logic [WK_W-1:0] wake_left;
  logic            ras_q;
  logic            fall;

  assign fall      = ras_q && !ras_n;
  assign wake_pend = (wake_left != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      pwr_cnt   <= '0;
      pwr_done  <= 1'b0;
      idle_cnt  <= '0;
      wake_left <= '0;
      ras_q     <= 1'b1;
    end else begin
      ras_q <= ras_n;
      // retention window: only row-strobe-high time counts
      if (!ras_n)
        idle_cnt <= '0;
      else if (idle_cnt != ID_W'(IDLE_LIMIT))
        idle_cnt <= idle_cnt + 1'b1;

      if (!pwr_done) begin
        if (pwr_cnt == PW_W'(P_PWRUP - 1)) begin
          pwr_done  <= 1'b1;
          wake_left <= WK_W'(WAKE_CNT);
        end else begin
          pwr_cnt <= pwr_cnt + 1'b1;
        end
      end else if (fall && wake_pend) begin
        wake_left <= wake_left - 1'b1;
      end else if (!wake_pend && idle_cnt == ID_W'(IDLE_LIMIT)) begin
        wake_left <= WK_W'(WAKE_CNT);
      end
    end
  end

  // R1: row strobe stays high through the whole power-up pause
  a_r1_no_ras_in_pause: assert property (@(posedge clk) disable iff (rst)
    !ras_n |-> pwr_done);

endmodule

// File: rtl/dseq_ras_span.sv
module dseq_ras_span #(
  parameter int T_RP      = 4,
  parameter int T_RAS_MAX = 2000
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              ras_n,
  output logic [$clog2(T_RAS_MAX+2)-1:0]    low_cnt
);

  localparam int LOW_W = $clog2(T_RAS_MAX + 2);
  localparam int HI_W  = $clog2(T_RP + 1);

  logic [HI_W-1:0] hi_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      low_cnt <= '0;
      hi_cnt  <= '0;
    end else begin
      if (ras_n) begin
        low_cnt <= '0;
        if (hi_cnt != HI_W'(T_RP))
          hi_cnt <= hi_cnt + 1'b1;
      end else begin
        hi_cnt <= '0;
        if (low_cnt != LOW_W'(T_RAS_MAX + 1))
          low_cnt <= low_cnt + 1'b1;
      end
    end
  end

  // R8: row strobe low time within budget
  a_r8_ras_budget: assert property (@(posedge clk) disable iff (rst)
    low_cnt <= LOW_W'(T_RAS_MAX));

  // R10: precharge time honoured before every row strobe fall
  a_r10_precharge: assert property (@(posedge clk) disable iff (rst)
    $fell(ras_n) |-> (hi_cnt >= HI_W'(T_RP)));

endmodule

// File: rtl/dram_seq.sv
module dram_seq
  import dseq_pkg::*;
#(
  parameter int ROW_W      = 9,
  parameter int COL_W      = 9,
  parameter int P_PWRUP    = 40000,
  parameter int WAKE_CNT   = 8,
  parameter int IDLE_LIMIT = 800000,
  parameter int T_RAS_MIN  = 8,
  parameter int T_RP       = 4,
  parameter int T_RCD      = 3,
  parameter int T_CAC      = 2,
  parameter int T_RAS_MAX  = 2000
) (
  input  logic                                        clk,
  input  logic                                        rst,
  input  logic                                        host_valid,
  input  logic [ROW_W+COL_W-1:0]                      host_addr,
  input  logic                                        host_write,
  input  logic                                        host_wdata,
  output logic                                        host_accept,
  output logic                                        host_done,
  output logic                                        host_rdata,
  input  logic                                        refr_req,
  input  logic [ROW_W-1:0]                            refr_row,
  output logic                                        refr_gnt,
  output logic                                        mem_ready,
  output logic                                        dram_ras_n,
  output logic                                        dram_cas_n,
  output logic                                        dram_we_n,
  output logic [((ROW_W>COL_W)?ROW_W:COL_W)-1:0]      dram_a,
  output logic                                        dram_d,
  input  logic                                        dram_q
);

  localparam int ADDR_W    = ROW_W + COL_W;
  localparam int A_W       = (ROW_W > COL_W) ? ROW_W : COL_W;
  localparam int LOW_W     = $clog2(T_RAS_MAX + 2);
  localparam int CNT_MAX   = (T_RCD > T_CAC ? T_RCD : T_CAC) > (T_RAS_MIN > T_RP ? T_RAS_MIN : T_RP)
                           ? (T_RCD > T_CAC ? T_RCD : T_CAC) : (T_RAS_MIN > T_RP ? T_RAS_MIN : T_RP);
  localparam int CNT_W     = $clog2(CNT_MAX + 1);
  // row-low clocks a further page column costs: accept, setup, access, one page clock
  localparam int PAGE_COST = T_CAC + 3;

  dseq_state_e       state;
  dseq_op_e          op;
  logic [CNT_W-1:0]  cnt;
  logic [ROW_W-1:0]  open_row;
  logic [COL_W-1:0]  col_q;
  logic              wr_q;
  logic              pwr_done;
  logic              wake_pend;
  logic [LOW_W-1:0]  low_cnt;
  logic [ROW_W-1:0]  h_row;
  logic [COL_W-1:0]  h_col;
  logic              budget_out;

  assign h_row      = host_addr[ADDR_W-1 -: ROW_W];
  assign h_col      = host_addr[COL_W-1:0];
  assign budget_out = (32'(low_cnt) + 32'(PAGE_COST)) > 32'(T_RAS_MAX);
  assign mem_ready  = pwr_done && !wake_pend;

  dseq_wake #(
    .P_PWRUP   (P_PWRUP),
    .WAKE_CNT  (WAKE_CNT),
    .IDLE_LIMIT(IDLE_LIMIT)
  ) u_wake (
    .clk      (clk),
    .rst      (rst),
    .ras_n    (dram_ras_n),
    .pwr_done (pwr_done),
    .wake_pend(wake_pend)
  );

  dseq_ras_span #(
    .T_RP     (T_RP),
    .T_RAS_MAX(T_RAS_MAX)
  ) u_span (
    .clk    (clk),
    .rst    (rst),
    .ras_n  (dram_ras_n),
    .low_cnt(low_cnt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      op          <= OP_HOST;
      cnt         <= '0;
      open_row    <= '0;
      col_q       <= '0;
      wr_q        <= 1'b0;
      dram_ras_n  <= 1'b1;
      dram_cas_n  <= 1'b1;
      dram_we_n   <= 1'b1;
      dram_a      <= '0;
      dram_d      <= 1'b0;
      host_accept <= 1'b0;
      host_done   <= 1'b0;
      host_rdata  <= 1'b0;
      refr_gnt    <= 1'b0;
    end else begin
      host_accept <= 1'b0;
      host_done   <= 1'b0;
      refr_gnt    <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (pwr_done) begin
            if (wake_pend) begin
              dram_a <= '0;
              op     <= OP_WAKE;
              state  <= ST_AROW;
            end else if (refr_req) begin
              dram_a   <= A_W'(refr_row);
              op       <= OP_REFRESH;
              refr_gnt <= 1'b1;
              state    <= ST_AROW;
            end else if (host_valid) begin
              dram_a      <= A_W'(h_row);
              open_row    <= h_row;
              col_q       <= h_col;
              wr_q        <= host_write;
              dram_d      <= host_wdata;
              host_accept <= 1'b1;
              op          <= OP_HOST;
              state       <= ST_AROW;
            end
          end
        end
        ST_AROW: begin
          dram_ras_n <= 1'b0;
          cnt        <= '0;
          state      <= (op == OP_HOST) ? ST_RCD : ST_RONLY;
        end
        ST_RCD: begin
          cnt <= cnt + 1'b1;
          if (cnt == '0) begin
            dram_a    <= A_W'(col_q);
            dram_we_n <= !wr_q;
          end
          if (cnt == CNT_W'(T_RCD - 1)) begin
            dram_cas_n <= 1'b0;
            cnt        <= '0;
            state      <= ST_CAS;
          end
        end
        ST_CAS: begin
          cnt <= cnt + 1'b1;
          if (cnt == CNT_W'(T_CAC - 1)) begin
            dram_cas_n <= 1'b1;
            dram_we_n  <= 1'b1;
            host_done  <= 1'b1;
            if (!wr_q)
              host_rdata <= dram_q;
            cnt   <= '0;
            state <= ST_PAGE;
          end
        end
        ST_PAGE: begin
          if (refr_req || budget_out || (host_valid && h_row != open_row)) begin
            dram_ras_n <= 1'b1;
            cnt        <= '0;
            state      <= ST_PRE;
          end else if (host_valid) begin
            dram_a      <= A_W'(h_col);
            dram_we_n   <= !host_write;
            wr_q        <= host_write;
            dram_d      <= host_wdata;
            host_accept <= 1'b1;
            state       <= ST_CPW;
          end
        end
        ST_CPW: begin
          dram_cas_n <= 1'b0;
          cnt        <= '0;
          state      <= ST_CAS;
        end
        ST_RONLY: begin
          cnt <= cnt + 1'b1;
          if (cnt == CNT_W'(T_RAS_MIN - 1)) begin
            dram_ras_n <= 1'b1;
            cnt        <= '0;
            state      <= ST_PRE;
          end
        end
        ST_PRE: begin
          cnt <= cnt + 1'b1;
          if (cnt == CNT_W'(T_RP - 1)) begin
            cnt   <= '0;
            state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R13: column strobe only inside a row strobe
  a_r13_cas_inside_ras: assert property (@(posedge clk) disable iff (rst)
    !dram_cas_n |-> !dram_ras_n);

  // R3: bus holds still across each strobe fall
  a_r3_row_addr_stable: assert property (@(posedge clk) disable iff (rst)
    $fell(dram_ras_n) |-> $stable(dram_a));
  a_r3_col_addr_stable: assert property (@(posedge clk) disable iff (rst)
    $fell(dram_cas_n) |-> $stable(dram_a));

  // R5: early write, write strobe leads the column strobe and holds
  a_r5_we_leads_cas: assert property (@(posedge clk) disable iff (rst)
    ($fell(dram_cas_n) && !dram_we_n) |-> ($past(dram_we_n) == 1'b0));
  a_r5_we_held: assert property (@(posedge clk) disable iff (rst)
    (!dram_cas_n && !$fell(dram_cas_n)) |-> $stable(dram_we_n));

  // R2: no column access before wake-up completes
  a_r2_cas_after_wake: assert property (@(posedge clk) disable iff (rst)
    $fell(dram_cas_n) |-> mem_ready);

  // R4: done is a single-cycle pulse
  a_r4_done_pulse: assert property (@(posedge clk) disable iff (rst)
    host_done |=> !host_done);

  // R9: grant is a single-cycle pulse
  a_r9_gnt_pulse: assert property (@(posedge clk) disable iff (rst)
    refr_gnt |=> !refr_gnt);

endmodule

// File: tb/test_dram_seq.sv
module test_dram_seq;

  localparam int ROW_W      = 9;
  localparam int COL_W      = 9;
  localparam int P_PWRUP    = 120;
  localparam int WAKE_CNT   = 8;
  localparam int IDLE_LIMIT = 1500;
  localparam int T_RAS_MIN  = 3;
  localparam int T_RP       = 3;
  localparam int T_RCD      = 3;
  localparam int T_CAC      = 2;
  localparam int T_RAS_MAX  = 40;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             host_valid = 1'b0;
  logic [17:0]      host_addr = '0;
  logic             host_write = 1'b0;
  logic             host_wdata = 1'b0;
  logic             host_accept, host_done, host_rdata;
  logic             refr_req = 1'b0;
  logic [8:0]       refr_row = '0;
  logic             refr_gnt, mem_ready;
  logic             dram_ras_n, dram_cas_n, dram_we_n, dram_d;
  logic [8:0]       dram_a;
  logic             dram_q = 1'b0;

  always #2.5 clk = ~clk;

  dram_seq #(
    .ROW_W(ROW_W), .COL_W(COL_W), .P_PWRUP(P_PWRUP), .WAKE_CNT(WAKE_CNT),
    .IDLE_LIMIT(IDLE_LIMIT), .T_RAS_MIN(T_RAS_MIN), .T_RP(T_RP),
    .T_RCD(T_RCD), .T_CAC(T_CAC), .T_RAS_MAX(T_RAS_MAX)
  ) i_dram_seq (
    .clk(clk), .rst(rst),
    .host_valid(host_valid), .host_addr(host_addr), .host_write(host_write),
    .host_wdata(host_wdata), .host_accept(host_accept), .host_done(host_done),
    .host_rdata(host_rdata), .refr_req(refr_req), .refr_row(refr_row),
    .refr_gnt(refr_gnt), .mem_ready(mem_ready), .dram_ras_n(dram_ras_n),
    .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n), .dram_a(dram_a),
    .dram_d(dram_d), .dram_q(dram_q)
  );

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // ---------------- memory model and monitor ----------------
  int  cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  bit         mon_on = 0;
  bit         mem [bit [17:0]];
  logic       ras_prev = 1'b1, cas_prev = 1'b1, we_prev = 1'b1;
  logic [8:0] a_prev = '0;
  logic [8:0] lat_row = '0, lat_col = '0;
  int ras_falls = 0, cas_falls = 0;
  int addr_viol = 0, prech_viol = 0, cas_viol = 0, early_viol = 0;
  int hi_run = 1000, low_run = 0, max_low = 0;
  int first_ras_cyc = -1, cas_fall_cyc = 0;
  bit ready_low_seen = 0;

  always @(negedge clk) begin
    if (mon_on) begin
      if (!mem_ready) ready_low_seen = 1;
      if (!dram_ras_n && ras_prev) begin
        ras_falls++;
        lat_row = dram_a;
        if (dram_a != a_prev) addr_viol++;
        if (hi_run < T_RP) prech_viol++;
        if (first_ras_cyc < 0) first_ras_cyc = cyc;
      end
      if (dram_ras_n) begin hi_run++; low_run = 0; end
      else begin
        hi_run = 0; low_run++;
        if (low_run > max_low) max_low = low_run;
      end
      if (!dram_cas_n && dram_ras_n) cas_viol++;
      if (!dram_cas_n && cas_prev) begin
        cas_falls++;
        lat_col = dram_a;
        cas_fall_cyc = cyc;
        if (dram_a != a_prev) addr_viol++;
        if (!dram_we_n) begin
          if (we_prev != 1'b0) early_viol++;
          mem[{lat_row, dram_a}] = dram_d;
        end else begin
          dram_q <= mem.exists({lat_row, dram_a}) ? mem[{lat_row, dram_a}] : 1'b0;
        end
      end
      ras_prev = dram_ras_n;
      cas_prev = dram_cas_n;
      we_prev  = dram_we_n;
      a_prev   = dram_a;
    end
  end

  // ---------------- helpers ----------------
  task automatic do_access(input logic [17:0] addr, input bit wr, input bit wd,
                           output bit rd, output int lat);
    int n;
    host_valid = 1'b1; host_addr = addr; host_write = wr; host_wdata = wd;
    n = 0;
    while (!host_accept && n < 3000) begin @(negedge clk); n++; end
    host_valid = 1'b0;
    if (n >= 3000) chk(0, "ACCEPT", 0, 1);
    n = 0;
    while (!host_done && n < 3000) begin @(negedge clk); n++; end
    if (n >= 3000) chk(0, "DONE", 0, 1);
    rd  = host_rdata;
    lat = cyc - cas_fall_cyc;
  endtask

  task automatic wait_ras_idle();
    int n = 0;
    while ((!dram_ras_n || hi_run < T_RP + 2) && n < 3000) begin @(negedge clk); n++; end
    #1;
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    repeat (4) @(negedge clk);
    chk(dram_ras_n == 1'b1, "R12 ras_n", dram_ras_n, 1);
    chk(dram_cas_n == 1'b1, "R12 cas_n", dram_cas_n, 1);
    chk(dram_we_n == 1'b1,  "R12 we_n",  dram_we_n, 1);
    chk(host_done == 1'b0,  "R12 done",  host_done, 0);
    chk(mem_ready == 1'b0,  "R12 ready", mem_ready, 0);
  endtask

  task automatic t_powerup(input int rel_cyc);
    int n = 0;
    while (!mem_ready && n < 5000) begin @(negedge clk); n++; end
    #1;
    chk(first_ras_cyc - rel_cyc >= P_PWRUP, "R1 pause", first_ras_cyc - rel_cyc, P_PWRUP);
    chk(ras_falls == WAKE_CNT, "R2 wake row cycles", ras_falls, WAKE_CNT);
    chk(cas_falls == 0, "R2 no column during wake", cas_falls, 0);
  endtask

  task automatic t_single();
    bit rd; int lat; int f0;
    wait_ras_idle();
    f0 = ras_falls;
    do_access({9'h005, 9'h007}, 1, 1, rd, lat);
    #1;
    chk(lat_row == 9'h005, "R3 row on bus", lat_row, 5);
    chk(lat_col == 9'h007, "R3 col on bus", lat_col, 7);
    chk(early_viol == 0, "R5 early write", early_viol, 0);
    do_access({9'h1F0, 9'h007}, 1, 0, rd, lat);
    do_access({9'h005, 9'h007}, 0, 0, rd, lat);
    chk(rd == 1'b1, "R4 read back 1", rd, 1);
    chk(lat == T_CAC, "R4 sample latency", lat, T_CAC);
    do_access({9'h1F0, 9'h007}, 0, 0, rd, lat);
    chk(rd == 1'b0, "R4 read back 0", rd, 0);
    chk(ras_falls - f0 == 4, "R7 row misses reopen", ras_falls - f0, 4);
  endtask

  task automatic t_page();
    bit rd; int lat; int f0, c0;
    wait_ras_idle();
    f0 = ras_falls; c0 = cas_falls;
    do_access({9'h0A3, 9'h001}, 1, 1, rd, lat);
    do_access({9'h0A3, 9'h002}, 1, 0, rd, lat);
    do_access({9'h0A3, 9'h001}, 0, 0, rd, lat);
    chk(rd == 1'b1, "R6 page read col1", rd, 1);
    do_access({9'h0A3, 9'h002}, 0, 0, rd, lat);
    chk(rd == 1'b0, "R6 page read col2", rd, 0);
    #1;
    chk(ras_falls - f0 == 1, "R6 one row strobe for burst", ras_falls - f0, 1);
    chk(cas_falls - c0 == 4, "R6 column strobes", cas_falls - c0, 4);
    // row miss straight out of the open page
    do_access({9'h0A4, 9'h002}, 0, 0, rd, lat);
    #1;
    chk(ras_falls - f0 == 2, "R7 miss closes page", ras_falls - f0, 2);
    chk(lat_row == 9'h0A4, "R7 new row latched", lat_row, 9'h0A4);
  endtask

  task automatic t_budget();
    bit rd; int lat; int f0;
    wait_ras_idle();
    f0 = ras_falls;
    for (int i = 0; i < 20; i++) do_access({9'h033, 9'(i)}, 1, i[0], rd, lat);
    for (int i = 0; i < 20; i++) begin
      do_access({9'h033, 9'(i)}, 0, 0, rd, lat);
      chk(rd == i[0], "R8 burst data", rd, i[0]);
    end
    #1;
    chk(ras_falls - f0 >= 3, "R8 burst split", ras_falls - f0, 3);
    chk(max_low <= T_RAS_MAX, "R8 max row low", max_low, T_RAS_MAX);
  endtask

  task automatic t_refresh();
    bit rd; int lat; int f0, c0, n;
    wait_ras_idle();
    f0 = ras_falls; c0 = cas_falls;
    refr_row = 9'h11C; refr_req = 1'b1;
    n = 0;
    while (!refr_gnt && n < 3000) begin @(negedge clk); n++; end
    refr_req = 1'b0;
    @(negedge clk);
    chk(refr_gnt == 1'b0, "R9 grant one cycle", refr_gnt, 0);
    repeat (20) @(negedge clk);
    #1;
    chk(ras_falls - f0 == 1, "R9 one row cycle", ras_falls - f0, 1);
    chk(cas_falls == c0, "R9 no column strobe", cas_falls - c0, 0);
    chk(lat_row == 9'h11C, "R9 refresh row", lat_row, 9'h11C);
    // refresh while a page is open
    do_access({9'h077, 9'h010}, 1, 1, rd, lat);
    refr_row = 9'h0E1; refr_req = 1'b1;
    n = 0;
    while (!refr_gnt && n < 3000) begin @(negedge clk); n++; end
    refr_req = 1'b0;
    repeat (20) @(negedge clk);
    #1;
    chk(ras_falls - f0 == 3, "R9 refresh closes page", ras_falls - f0, 3);
    chk(lat_row == 9'h0E1, "R9 refresh row in page", lat_row, 9'h0E1);
  endtask

  task automatic t_rewake();
    bit rd; int lat; int f0, c0, n;
    wait_ras_idle();
    ready_low_seen = 0;
    f0 = ras_falls; c0 = cas_falls;
    repeat (IDLE_LIMIT + 50) @(negedge clk);
    n = 0;
    while (!mem_ready && n < 3000) begin @(negedge clk); n++; end
    #1;
    chk(ready_low_seen == 1, "R11 ready dropped", ready_low_seen, 1);
    chk(ras_falls - f0 == WAKE_CNT, "R11 wake again", ras_falls - f0, WAKE_CNT);
    chk(cas_falls == c0, "R11 no column in wake", cas_falls - c0, 0);
    do_access({9'h077, 9'h010}, 0, 0, rd, lat);
    chk(rd == 1'b1, "R11 data after wake", rd, 1);
  endtask

  task automatic t_timing();
    #1;
    chk(addr_viol == 0, "R3 bus stable at strobes", addr_viol, 0);
    chk(prech_viol == 0, "R10 precharge", prech_viol, 0);
    chk(cas_viol == 0, "R13 column inside row", cas_viol, 0);
    chk(early_viol == 0, "R5 write strobe early", early_viol, 0);
    chk(max_low <= T_RAS_MAX, "R8 row low overall", max_low, T_RAS_MAX);
  endtask

  initial begin
    int rel;
    t_reset();
    @(negedge clk);
    rst = 1'b0;
    mon_on = 1;
    rel = cyc;
    t_powerup(rel);
    t_single();
    t_page();
    t_budget();
    t_refresh();
    t_rewake();
    t_timing();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule